// File: doc/BRIEF.md
# Shift and Rotate Unit

This is a purely combinational datapath element for an integer execution pipeline. It moves a byte, word or long operand left or right by a count of 0 to 63. Four kinds of movement are offered: logical shift, arithmetic shift, plain rotate, and rotate through an extend bit. A one-cycle operation needs no clock, so the unit takes none. The caller supplies the full-width register value. Only the low 8, 16 or 32 bits take part. The bits above the selected size come back untouched, so the result can be written straight back to the register.

Besides the result, the unit produces five condition flags. An extend flag (X) is kept apart from the carry (C). Shifts and extended rotates load X with the last bit that left the operand. Plain rotates leave X alone. The extended rotates treat X as one more bit of the ring, which makes the ring one bit wider than the operand. A negative flag (N), a zero flag (Z) and an overflow flag (V) complete the set. V can only be set by an arithmetic left shift.

Top module: `shift_rotate_unit`

## Requirements
- R1: `size_i` selects the operand width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 and 2'b11 are 32 bits. Result bits above the selected width always equal the matching `operand_i` bits.
- R2: A logical shift (`op_i` = 2'b00) fills vacated positions with zero, in both directions (`left_i` = 1 means left). C is the last bit moved out, which is zero when the count exceeds the width on a left shift.
- R3: An arithmetic right shift (`op_i` = 2'b01, `left_i` = 0) fills vacated positions with the operand's sign bit. A count at or beyond the width gives all sign bits, and C equals the sign bit.
- R4: An arithmetic left shift gives the same result as a logical left shift. It sets V when the operand's top bit takes more than one value over the course of the shift.
- R5: A plain rotate (`op_i` = 2'b10) circulates the operand within its own width. C is the bit last carried around: result bit 0 after a left rotate, the result's top bit after a right rotate. X passes through unchanged.
- R6: An extended rotate (`op_i` = 2'b11) circulates a ring of width+1 bits, with X as the extra bit above the top of the operand. X and C both come out as the bit that ends up in that position. A count that is a multiple of width+1 returns the operand unchanged.
- R7: For nonzero counts on either kind of shift, X and C both equal the last bit moved out.
- R8: A count of zero returns the operand unchanged and leaves X unchanged. C is then cleared, except on an extended rotate, where C is set equal to the incoming X.
- R9: N is the top bit of the result at the selected width. Z is set exactly when the result's low bits at that width are all zero, whatever the upper bits hold.
- R10: V is zero for every operation other than an arithmetic left shift, and for a zero count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Full register value to be moved |
| size_i | input | 2 | Operand width select |
| op_i | input | 2 | Operation kind: logical, arithmetic, rotate, extended rotate |
| left_i | input | 1 | Direction, 1 for left and 0 for right |
| count_i | input | 6 | Number of bit positions, 0 to 63 |
| x_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Moved value, with upper bits kept from the operand |
| x_o | output | 1 | Outgoing extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
Hand-picked vectors put a set bit exactly at the edge that leaves the operand, and use operands with dirty upper bits. These tell a right edge-bit choice from an off-by-one, and a width-masked result from a full-width one. Sign-heavy operands at counts of 0, 1, the width, the width plus one and 63 separate sign fill from zero fill, and the modulus of a size-wide ring from that of a size+1 ring. A bit-by-bit stepping model then runs every size, kind, direction and count against four operands: all ones, alternating bits, a lone top bit, and a mixed value. This sweep shows whether X and C are kept apart in each case, and whether V follows every change of the top bit rather than just the first and last values.

// File: rtl/sr_pkg.sv
// Shared types for the shift and rotate unit.
// Assumes: operation and size codes are fixed by the instruction decoder.
package sr_pkg;

    typedef enum logic [1:0] {
        OP_LSH = 2'b00,   // logical shift
        OP_ASH = 2'b01,   // arithmetic shift
        OP_ROT = 2'b10,   // rotate within operand
        OP_ROX = 2'b11    // rotate through extend bit
    } sr_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11   // alias of long
    } sr_size_e;

endpackage

// File: rtl/sr_operand_prep.sv
// Operand preparation: turns the size code into a bit count and a low mask,
// and clears everything above the selected width.
// Assumes: DATA_W is at least 32, so byte and word fit inside it.
module sr_operand_prep #(
    parameter int DATA_W = 32,
    parameter int NB_W   = $clog2(DATA_W) + 2
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [NB_W-1:0]   nbits_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] data_o
);
    import sr_pkg::*;

    // Decode width, build the low mask and trim the operand.
    always_comb begin
        case (sr_size_e'(size_i))
            SZ_BYTE: nbits_o = NB_W'(8);
            SZ_WORD: nbits_o = NB_W'(16);
            default: nbits_o = NB_W'(DATA_W);
        endcase
        mask_o = ~({DATA_W{1'b1}} << nbits_o);
        data_o = operand_i & mask_o;
    end

endmodule

// File: rtl/sr_shift_core.sv
// Logical and arithmetic shifts in both directions, with the last bit out
// and the arithmetic-left overflow indication.
// Assumes: data_i is already trimmed to nbits_i; count_i < 2*DATA_W.
module sr_shift_core #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int NB_W   = $clog2(DATA_W) + 2
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [NB_W-1:0]   nbits_i,
    input  logic              arith_i,
    input  logic              left_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int WIDE = 2 * DATA_W;

    logic [WIDE-1:0]   up_w;
    logic [WIDE-1:0]   up_tap;
    logic [WIDE-1:0]   ext_w;
    logic [2*WIDE-1:0] dn_w;
    logic [DATA_W-1:0] sign_tap;
    logic              sign;
    logic              any_one;
    logic              any_zero;
    int                lo;

    // Left path: widen, shift, take the bit that crossed the width boundary.
    always_comb begin
        up_w   = WIDE'(data_i) << count_i;
        up_tap = up_w >> nbits_i;
    end

    // Right path: extend with sign or zero, shift into a lower half that
    // keeps the last bit out just below the result.
    always_comb begin
        sign_tap = data_i >> (nbits_i - NB_W'(1));
        sign     = sign_tap[0];
        ext_w    = WIDE'(data_i) | ((arith_i && sign) ? ~WIDE'(mask_i) : '0);
        dn_w     = $signed({ext_w, {WIDE{1'b0}}}) >>> count_i;
    end

    // Overflow: top bit history is the window of count+1 bits below the top,
    // plus a shifted-in zero once the count reaches the width.
    always_comb begin
        lo       = int'(nbits_i) - 1 - int'(count_i);
        any_one  = 1'b0;
        any_zero = (int'(count_i) >= int'(nbits_i));
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= lo && i < int'(nbits_i)) begin
                any_one  = any_one | data_i[i];
                any_zero = any_zero | ~data_i[i];
            end
        end
        ovf_o = arith_i && left_i && (count_i != '0) && any_one && any_zero;
    end

    // Direction select for result and carry.
    always_comb begin
        if (left_i) begin
            res_o  = up_w[DATA_W-1:0] & mask_i;
            cout_o = (count_i != '0) && up_tap[0];
        end else begin
            res_o  = dn_w[WIDE +: DATA_W] & mask_i;
            cout_o = (count_i != '0) && dn_w[WIDE-1];
        end
    end

endmodule

// File: rtl/sr_rotate_core.sv
// Plain rotate within the operand width and extended rotate through X,
// where the ring is one bit wider than the operand.
// Assumes: data_i is trimmed to nbits_i; the smallest width is 8 bits.
module sr_rotate_core #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int NB_W   = $clog2(DATA_W) + 2
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [NB_W-1:0]   nbits_i,
    input  logic              extend_i,
    input  logic              left_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              x_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              xout_o
);
    localparam int WIDE     = 2 * DATA_W;
    localparam int MOD_ITER = (1 << CNT_W) / 8 + 1;

    int                rw;
    int                rem;
    int                lamt;
    logic [WIDE-1:0]   ring;
    logic [WIDE-1:0]   rmask;
    logic [WIDE-1:0]   rot;
    logic [WIDE-1:0]   xtap;
    logic [DATA_W-1:0] mtap;

    // Reduce the count modulo the ring width by bounded subtraction.
    always_comb begin
        rw  = int'(nbits_i) + (extend_i ? 1 : 0);
        rem = int'(count_i);
        for (int k = 0; k < MOD_ITER; k++) begin
            if (rem >= rw) rem = rem - rw;
        end
        lamt = left_i ? rem : ((rem == 0) ? 0 : rw - rem);
    end

    // Build the ring, rotate it left by the equivalent amount.
    always_comb begin
        ring  = WIDE'(data_i) | ((extend_i && x_i) ? (WIDE'(1) << nbits_i) : '0);
        rmask = ~({WIDE{1'b1}} << rw);
        rot   = ((ring << lamt) | (ring >> (rw - lamt))) & rmask;
        res_o = rot[DATA_W-1:0] & mask_i;
        xtap  = rot >> nbits_i;
        mtap  = res_o >> (nbits_i - NB_W'(1));
    end

    // Carry and extend outputs for both rotate kinds.
    always_comb begin
        if (extend_i) begin
            cout_o = (count_i == '0) ? x_i : xtap[0];
            xout_o = (count_i == '0) ? x_i : xtap[0];
        end else begin
            cout_o = (count_i != '0) && (left_i ? res_o[0] : mtap[0]);
            xout_o = x_i;
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Shift and rotate unit: selects the shift or rotate core by operation,
// restores the bits above the selected width and forms X, N, Z, V, C.
// Assumes: purely combinational use inside one execute cycle.
module shift_rotate_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        op_i,
    input  logic              left_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              x_i,
    output logic [DATA_W-1:0] result_o,
    output logic              x_o,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o,
    output logic              c_o
);
    import sr_pkg::*;

    localparam int NB_W = $clog2(DATA_W) + 2;

    sr_op_e            op;
    logic [NB_W-1:0]   nbits;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] rt_res;
    logic [DATA_W-1:0] core_res;
    logic [DATA_W-1:0] ntap;
    logic              sh_c;
    logic              sh_v;
    logic              rt_c;
    logic              rt_x;
    logic              is_shift;

    assign op       = sr_op_e'(op_i);
    assign is_shift = (op == OP_LSH) || (op == OP_ASH);

    sr_operand_prep #(.DATA_W(DATA_W), .NB_W(NB_W)) u_prep (
        .size_i    (size_i),
        .operand_i (operand_i),
        .nbits_o   (nbits),
        .mask_o    (mask),
        .data_o    (data)
    );

    sr_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_shift (
        .data_i  (data),
        .mask_i  (mask),
        .nbits_i (nbits),
        .arith_i (op == OP_ASH),
        .left_i  (left_i),
        .count_i (count_i),
        .res_o   (sh_res),
        .cout_o  (sh_c),
        .ovf_o   (sh_v)
    );

    sr_rotate_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_rot (
        .data_i   (data),
        .mask_i   (mask),
        .nbits_i  (nbits),
        .extend_i (op == OP_ROX),
        .left_i   (left_i),
        .count_i  (count_i),
        .x_i      (x_i),
        .res_o    (rt_res),
        .cout_o   (rt_c),
        .xout_o   (rt_x)
    );

    // Merge core outputs and restore the untouched upper bits.
    always_comb begin
        core_res = is_shift ? sh_res : rt_res;
        result_o = (operand_i & ~mask) | core_res;
        ntap     = result_o >> (nbits - NB_W'(1));
        n_o      = ntap[0];
        z_o      = (result_o & mask) == '0;
        v_o      = is_shift ? sh_v : 1'b0;
        c_o      = is_shift ? sh_c : rt_c;
        if (count_i == '0) x_o = x_i;
        else if (is_shift) x_o = sh_c;
        else               x_o = rt_x;
    end

endmodule

// File: rtl/shift_rotate_unit_chk.sv
// Checker for the shift and rotate unit: port-level rules on flags and
// preserved bits, evaluated whenever the inputs settle.
// Assumes: combinational top, so immediate assertions are used.
module shift_rotate_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic [DATA_W-1:0] operand_i,
    input logic [1:0]        size_i,
    input logic [1:0]        op_i,
    input logic              left_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              x_i,
    input logic [DATA_W-1:0] result_o,
    input logic              x_o,
    input logic              n_o,
    input logic              z_o,
    input logic              v_o,
    input logic              c_o
);
    // Port rules checked on every input change.
    always_comb begin
        if (size_i == 2'b00) begin
            p_byte_upper_r1: assert (result_o[DATA_W-1:8] == operand_i[DATA_W-1:8])
                else $error("upper bits altered on byte operation");
        end
        if (size_i == 2'b01) begin
            p_word_upper_r1: assert (result_o[DATA_W-1:16] == operand_i[DATA_W-1:16])
                else $error("upper bits altered on word operation");
        end
        if (op_i == 2'b10) begin
            p_rot_keeps_x_r5: assert (x_o == x_i)
                else $error("plain rotate changed X");
        end
        if (count_i == '0 && op_i == 2'b11) begin
            p_rox_zero_c_r6: assert (c_o == x_i)
                else $error("extended rotate by zero: C differs from X");
        end
        if (count_i != '0 && op_i[1] == 1'b0) begin
            p_shift_xc_r7: assert (x_o == c_o)
                else $error("shift left X and C different");
        end
        if (count_i == '0) begin
            p_zero_count_r8: assert (x_o == x_i && result_o == operand_i)
                else $error("zero count changed result or X");
        end
        p_no_neg_zero_r9: assert (!(n_o && z_o))
            else $error("N and Z both set");
        p_v_only_asl_r10: assert (!v_o || (op_i == 2'b01 && left_i && count_i != '0))
            else $error("V set outside arithmetic left shift");
    end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .operand_i (operand_i),
    .size_i    (size_i),
    .op_i      (op_i),
    .left_i    (left_i),
    .count_i   (count_i),
    .x_i       (x_i),
    .result_o  (result_o),
    .x_o       (x_o),
    .n_o       (n_o),
    .z_o       (z_o),
    .v_o       (v_o),
    .c_o       (c_o)
);

// File: tb/shift_rotate_unit_test.sv
// Bench for the shift and rotate unit: a hand-computed vector table, a
// directed idle check, then a sweep against a bit-stepping model.
module shift_rotate_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = '0;
    logic [1:0]  size_i = '0;
    logic [1:0]  op_i = '0;
    logic        left_i = 1'b0;
    logic [5:0]  count_i = '0;
    logic        x_i = 1'b0;
    logic [31:0] result_o;
    logic        x_o, n_o, z_o, v_o, c_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_rotate_unit uut (
        .operand_i (operand_i),
        .size_i    (size_i),
        .op_i      (op_i),
        .left_i    (left_i),
        .count_i   (count_i),
        .x_i       (x_i),
        .result_o  (result_o),
        .x_o       (x_o),
        .n_o       (n_o),
        .z_o       (z_o),
        .v_o       (v_o),
        .c_o       (c_o)
    );

    // Entry: size, op, left, count, x, operand, expected result, flags XNZVC.
    localparam logic [80:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 1'b1, 6'd1,  1'b0, 32'h000000C1, 32'h00000082, 5'b11001},
        {2'd0, 2'd0, 1'b0, 6'd3,  1'b0, 32'hFFFFFF81, 32'hFFFFFF10, 5'b00000},
        {2'd1, 2'd1, 1'b0, 6'd4,  1'b1, 32'h12348000, 32'h1234F800, 5'b01000},
        {2'd1, 2'd1, 1'b1, 6'd1,  1'b0, 32'h00004000, 32'h00008000, 5'b01010},
        {2'd2, 2'd1, 1'b1, 6'd2,  1'b0, 32'h20000000, 32'h80000000, 5'b01010},
        {2'd2, 2'd1, 1'b1, 6'd1,  1'b0, 32'hC0000001, 32'h80000002, 5'b11001},
        {2'd0, 2'd2, 1'b1, 6'd1,  1'b0, 32'h00000081, 32'h00000003, 5'b00001},
        {2'd0, 2'd2, 1'b0, 6'd1,  1'b1, 32'h00000001, 32'h00000080, 5'b11001},
        {2'd0, 2'd3, 1'b1, 6'd1,  1'b0, 32'h00000080, 32'h00000000, 5'b10101},
        {2'd0, 2'd3, 1'b0, 6'd1,  1'b1, 32'h00000001, 32'h00000080, 5'b11001},
        {2'd0, 2'd3, 1'b1, 6'd9,  1'b1, 32'h0000005A, 32'h0000005A, 5'b10001},
        {2'd2, 2'd0, 1'b1, 6'd0,  1'b1, 32'h80000000, 32'h80000000, 5'b11000},
        {2'd0, 2'd3, 1'b0, 6'd0,  1'b1, 32'h00000000, 32'h00000000, 5'b10101},
        {2'd2, 2'd0, 1'b1, 6'd40, 1'b0, 32'hFFFFFFFF, 32'h00000000, 5'b00100},
        {2'd2, 2'd1, 1'b0, 6'd63, 1'b0, 32'h80000000, 32'hFFFFFFFF, 5'b11001},
        {2'd1, 2'd0, 1'b0, 6'd16, 1'b0, 32'hABCD8000, 32'hABCD0000, 5'b10101},
        {2'd0, 2'd2, 1'b1, 6'd8,  1'b0, 32'h00000081, 32'h00000081, 5'b01001},
        {2'd3, 2'd0, 1'b0, 6'd1,  1'b0, 32'h00000003, 32'h00000001, 5'b10001}
    };

    // Requirement named by each table entry.
    function automatic string vec_req(int idx);
        case (idx)
            0, 13:        return "R2";
            1, 17:        return "R1";
            2, 14:        return "R3";
            3, 4, 5:      return "R4";
            6, 7, 16:     return "R5";
            8, 9, 10:     return "R6";
            11, 12:       return "R8";
            default:      return "R9";
        endcase
    endfunction

    // Requirement named by each operation kind in the sweep.
    function automatic string op_req(logic [1:0] op, logic left);
        case (op)
            2'd0:    return "R7";
            2'd1:    return left ? "R4" : "R3";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // Bit-stepping model: moves one position per step; returns {result, XNZVC}.
    function automatic logic [36:0] model(logic [1:0] sz, logic [1:0] op, logic left,
                                          int cnt, logic xin, logic [31:0] opd);
        int          n;
        logic [31:0] mask, d;
        logic        x, c, v, outb, sgn;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (n == 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 32'd1);
        d    = opd & mask;
        x = xin; c = 1'b0; v = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            sgn = d[n-1];
            if (left) begin
                outb = d[n-1];
                case (op)
                    2'd2:    d = ((d << 1) | {31'd0, outb}) & mask;
                    2'd3:    d = ((d << 1) | {31'd0, x}) & mask;
                    default: d = (d << 1) & mask;
                endcase
                if (op == 2'd1 && d[n-1] != sgn) v = 1'b1;
            end else begin
                outb = d[0];
                case (op)
                    2'd1:    d = (d >> 1) | (sgn ? (32'd1 << (n-1)) : 32'd0);
                    2'd2:    d = (d >> 1) | (outb ? (32'd1 << (n-1)) : 32'd0);
                    2'd3:    d = (d >> 1) | (x ? (32'd1 << (n-1)) : 32'd0);
                    default: d = d >> 1;
                endcase
            end
            c = outb;
            if (op != 2'd2) x = outb;
        end
        if (cnt == 0 && op == 2'd3) c = x;
        return {(opd & ~mask) | d, x, d[n-1], (d == 32'd0), v, c};
    endfunction

    // Drive one vector after a rising edge, compare at the falling edge.
    task automatic apply(logic [1:0] sz, logic [1:0] op, logic left, logic [5:0] cnt,
                         logic xin, logic [31:0] opd, logic [31:0] exp_res,
                         logic [4:0] exp_fl, string req);
        logic [36:0] got;
        @(posedge clk);
        size_i = sz; op_i = op; left_i = left; count_i = cnt; x_i = xin; operand_i = opd;
        @(negedge clk);
        got = {result_o, x_o, n_o, z_o, v_o, c_o};
        n_checks++;
        if (got !== {exp_res, exp_fl}) begin
            n_fail++;
            $display("FAIL %s: sz=%0d op=%0d left=%0d cnt=%0d x=%0d opd=%h got %h/%b expected %h/%b",
                     req, sz, op, left, cnt, xin, opd, got[36:5], got[4:0], exp_res, exp_fl);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs: zero result, only Z set (R9, R8).
        apply(2'd0, 2'd0, 1'b0, 6'd0, 1'b0, 32'h0, 32'h0, 5'b00100, "R8");

        // Hand-computed table.
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][80:79], VEC[i][78:77], VEC[i][76], VEC[i][75:70], VEC[i][69],
                  VEC[i][68:37], VEC[i][36:5], VEC[i][4:0], vec_req(i));
        end

        // Directed corners: word extended rotate wrapping at 17 (R6),
        // plain rotate never touching X (R5), V absent on right shifts (R10).
        apply(2'd1, 2'd3, 1'b0, 6'd17, 1'b0, 32'hFFFF1234, 32'hFFFF1234, 5'b00000, "R6");
        apply(2'd2, 2'd2, 1'b0, 6'd33, 1'b1, 32'h00000001, 32'h80000000, 5'b11001, "R5");
        apply(2'd0, 2'd1, 1'b0, 6'd2,  1'b0, 32'h00000040, 32'h00000010, 5'b00000, "R10");

        // Sweep against the stepping model.
        for (int o = 0; o < 4; o++) begin
            logic [31:0] opd;
            opd = (o == 0) ? 32'hFFFFFFFF : (o == 1) ? 32'h5A5AA5A5 :
                  (o == 2) ? 32'h80008080 : 32'h3C91E607;
            for (int sz = 0; sz < 3; sz++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        for (int cnt = 0; cnt < 64; cnt++) begin
                            logic [36:0] e;
                            logic        xin;
                            xin = cnt[0] ^ o[0];
                            e = model(sz[1:0], op[1:0], dir[0], cnt, xin, opd);
                            apply(sz[1:0], op[1:0], dir[0], cnt[5:0], xin, opd,
                                  e[36:5], e[4:0], op_req(op[1:0], dir[0]));
                        end
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule